// File: doc/BRIEF.md
# Wishbone Burst RAM Slave

This block is a synchronous, single-port on-chip memory that sits behind a Wishbone slave port. A master can use plain single-beat cycles, or it can use registered-feedback incrementing bursts. In a burst the slave works out each next word address by itself, so it can return one acknowledge on every clock. The supported burst shapes are linear and wrapping over 4, 8 or 16 words. Writes are applied per byte lane under the select bits.

The memory is word-addressed. The data width and the address width are parameters, and so are byte-lane gating and burst support. With burst support off, every access runs at the classic rhythm of one acknowledge every two clocks. A small tag input is accepted and ignored. The error and retry outputs are always low. Reset is synchronous and active high. It clears the handshake and the burst address state, and it leaves the stored words unchanged.

Top module: `wb_burst_ram`

## Requirements
- R1: When stb and cyc are both high and no ack is pending, ack rises in the next clock. In that cycle the read data holds the word at the presented address. A write is committed with the data held during the ack cycle.
- R2: Select bit i guards data bits [8i+7:8i]. With lane gating disabled (LANE_WR=0), a write replaces the whole word whatever the select bits are.
- R3: After each non-burst ack, ack is low for at least one clock. A master that holds stb high with a new address therefore gets one ack every two clocks.
- R4: A cycle-type value of 3'b010 marks an incrementing burst. While stb stays high, ack stays high on consecutive clocks. Each beat after the first uses the internally generated address, not the bus address.
- R5: A burst-type value of 2'b00 is linear. The next word address is the current one plus one, and it rolls from the top of the address space to zero.
- R6: Burst-type values 2'b01, 2'b10 and 2'b11 wrap over 4, 8 and 16 words. Only the low 2, 3 or 4 address bits advance, modulo the length, and the upper bits stay fixed.
- R7: A beat with cycle type 3'b111 receives the final ack of the burst, and ack is low on the next clock. The access after it uses the bus address.
- R8: Cycle-type values other than 3'b010 are served as single-beat cycles, with the same timing as R3. This includes 3'b000, the constant-address value 3'b001, 3'b111 and the unused codes.
- R9: If stb falls during a burst, ack is low in that same cycle. When stb returns, the access restarts from the bus address after one wait cycle.
- R10: With BURST_EN=0, an incrementing cycle type still gets only single-beat handling: ack high for one clock, then low.
- R11: The tag input has no effect on data or timing, and err and rty are always low.
- R12: Reset clears any pending ack and the burst state. Memory contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_dat_i | input | DATA_W | Write data |
| wb_sel_i | input | DATA_W/8 | Byte-lane selects |
| wb_adr_i | input | ADDR_W | Word address |
| wb_tag_i | input | TAG_W | Tag, ignored |
| wb_cti_i | input | 3 | Cycle-type identifier |
| wb_bte_i | input | 2 | Burst-type extension |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_we_i | input | 1 | Write enable |
| wb_dat_o | output | DATA_W | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_err_o | output | 1 | Error, always low |
| wb_rty_o | output | 1 | Retry, always low |

## Verification
The hardest situation to reach from the ports is a burst that resumes after its strobe has dropped. The ack register is still set and the internal address has already moved ahead, yet the slave must restart from the bus address with a wait cycle. The stimulus reaches this by removing stb for one clock at a chosen beat inside a burst, in both directed and random bursts. To show that the address is generated internally, beats after the first often carry a random bus address. Directed wrap bursts, and a linear burst that runs over the top of memory, cover the address-arithmetic corners.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  localparam int CTI_W  = 3;
  localparam int BTE_W  = 2;
  localparam int LANE_W = 8;

  typedef enum logic [CTI_W-1:0] {
    CTI_SINGLE = 3'b000,
    CTI_FIXED  = 3'b001,
    CTI_STEP   = 3'b010,
    CTI_LAST   = 3'b111
  } cti_e;

  typedef enum logic [BTE_W-1:0] {
    BTE_LINEAR = 2'b00,
    BTE_WRAP4  = 2'b01,
    BTE_WRAP8  = 2'b10,
    BTE_WRAP16 = 2'b11
  } bte_e;

  // Mask of the address bits that advance inside a wrapping burst;
  // zero means the whole address advances (linear).
  function automatic logic [3:0] wrap_span_mask(input logic [BTE_W-1:0] bte);
    case (bte)
      BTE_WRAP4:  return 4'h3;
      BTE_WRAP8:  return 4'h7;
      BTE_WRAP16: return 4'hF;
      default:    return 4'h0;
    endcase
  endfunction

  function automatic logic is_step_burst(input logic [CTI_W-1:0] cti);
    return cti == CTI_STEP;
  endfunction

endpackage

// File: rtl/wbr_ack_ctrl.sv
module wbr_ack_ctrl
  import wbr_pkg::*;
#(
  parameter int BURST_EN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             cyc_i,
  input  logic [CTI_W-1:0] cti_i,
  output logic             ack_o,
  output logic             load_o,
  output logic             adv_o
);

  logic ack_q;
  logic req;
  logic keep_going;
  logic ack_d;

  assign req        = stb_i & cyc_i;
  assign keep_going = (BURST_EN != 0) && is_step_burst(cti_i);
  assign ack_o      = ack_q & req;
  // Fresh request: acknowledge next clock. Acked beat: continue only in a step burst.
  assign ack_d      = req & (ack_o ? keep_going : 1'b1);
  assign load_o     = ack_d;
  assign adv_o      = ack_o & keep_going;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= ack_d;
  end

  p_ack_after_req_r1: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(stb_i && cyc_i));

  p_single_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !keep_going) |=> !ack_o);

  p_burst_streams_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_o && keep_going) |=> (ack_o || !(stb_i && cyc_i)));

  p_drop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !(stb_i && cyc_i) |=> !ack_o);

endmodule

// File: rtl/wbr_beat_addr.sv
module wbr_beat_addr
  import wbr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BURST_EN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BTE_W-1:0]  bte_i,
  input  logic              ack_i,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);

  logic [ADDR_W-1:0] beat_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] cur,
                                                  input logic [BTE_W-1:0]  bte);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'(wrap_span_mask(bte));
    if (m == '0) return cur + 1'b1;
    return (cur & ~m) | ((cur + 1'b1) & m);
  endfunction

  generate
    if (BURST_EN != 0) begin : g_burst
      // While an ack is out, fetch ahead for the following beat.
      assign rd_addr_o = ack_i ? step_addr(beat_q, bte_i) : addr_i;
    end else begin : g_single
      assign rd_addr_o = addr_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         beat_q <= '0;
    else if (load_i) beat_q <= rd_addr_o;
  end

  assign wr_addr_o = beat_q;

  p_burst_moves_r4: assert property (@(posedge clk) disable iff (rst)
    $past(adv_i) |-> (beat_q != $past(beat_q)));

  p_wrap_upper_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(adv_i) && ($past(bte_i) != BTE_LINEAR)) |->
      (((beat_q ^ $past(beat_q)) & ~ADDR_W'(wrap_span_mask($past(bte_i)))) == {ADDR_W{1'b0}}));

endmodule

// File: rtl/wbr_store.sv
module wbr_store
  import wbr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int LANE_WR = 1
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W/LANE_W-1:0]   sel,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rdata
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] q;
      logic              lane_we;

      assign lane_we = wr_en & ((LANE_WR == 0) | sel[g]);

      always_ff @(posedge clk) begin
        if (lane_we) cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        q <= cells[rd_addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = q;
    end
  endgenerate

endmodule

// File: rtl/wb_burst_ram.sv
module wb_burst_ram
  import wbr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int LANE_WR  = 1,
  parameter int BURST_EN = 1,
  parameter int TAG_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        wb_dat_i,
  input  logic [DATA_W/8-1:0]      wb_sel_i,
  input  logic [ADDR_W-1:0]        wb_adr_i,
  input  logic [TAG_W-1:0]         wb_tag_i,
  input  logic [2:0]               wb_cti_i,
  input  logic [1:0]               wb_bte_i,
  input  logic                     wb_stb_i,
  input  logic                     wb_cyc_i,
  input  logic                     wb_we_i,
  output logic [DATA_W-1:0]        wb_dat_o,
  output logic                     wb_ack_o,
  output logic                     wb_err_o,
  output logic                     wb_rty_o
);

  logic              ack;
  logic              load;
  logic              adv;
  logic              wr_fire;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              unused_tag;

  assign unused_tag = ^wb_tag_i;

  wbr_ack_ctrl #(.BURST_EN(BURST_EN)) u_ack (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (wb_stb_i),
    .cyc_i  (wb_cyc_i),
    .cti_i  (wb_cti_i),
    .ack_o  (ack),
    .load_o (load),
    .adv_o  (adv)
  );

  wbr_beat_addr #(.ADDR_W(ADDR_W), .BURST_EN(BURST_EN)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (wb_adr_i),
    .bte_i     (wb_bte_i),
    .ack_i     (ack),
    .load_i    (load),
    .adv_i     (adv),
    .rd_addr_o (rd_addr),
    .wr_addr_o (wr_addr)
  );

  // A beat is written in the cycle its acknowledge is out.
  assign wr_fire = ack & wb_we_i;

  wbr_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_WR(LANE_WR)) u_mem (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .sel     (wb_sel_i),
    .wdata   (wb_dat_i),
    .rd_addr (rd_addr),
    .rdata   (wb_dat_o)
  );

  assign wb_ack_o = ack;
  assign wb_err_o = 1'b0;
  assign wb_rty_o = 1'b0;

endmodule

// File: tb/wb_burst_ram_test.sv
module wb_burst_ram_test;

  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dat = '0;
  logic [3:0]  sel = '0;
  logic [11:0] adr = '0;
  logic [2:0]  tag = '0;
  logic [2:0]  cti = '0;
  logic [1:0]  bte = '0;
  logic        stb = 1'b0;
  logic        cyc = 1'b0;
  logic        we  = 1'b0;
  logic        en2 = 1'b0;
  logic        stb2;
  logic [31:0] dat_o, dat2;
  logic        ack, err, rty, ack2, err2, rty2;

  always #4 clk = ~clk;
  assign stb2 = stb & en2;

  wb_burst_ram uut (
    .clk(clk), .rst(rst), .wb_dat_i(dat), .wb_sel_i(sel), .wb_adr_i(adr),
    .wb_tag_i(tag), .wb_cti_i(cti), .wb_bte_i(bte), .wb_stb_i(stb),
    .wb_cyc_i(cyc), .wb_we_i(we), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .wb_err_o(err), .wb_rty_o(rty));

  wb_burst_ram #(.DATA_W(32), .ADDR_W(4), .LANE_WR(0), .BURST_EN(0), .TAG_W(3)) uut2 (
    .clk(clk), .rst(rst), .wb_dat_i(dat), .wb_sel_i(sel), .wb_adr_i(adr[3:0]),
    .wb_tag_i(tag), .wb_cti_i(cti), .wb_bte_i(bte), .wb_stb_i(stb2),
    .wb_cyc_i(cyc), .wb_we_i(we), .wb_dat_o(dat2), .wb_ack_o(ack2),
    .wb_err_o(err2), .wb_rty_o(rty2));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] shadow  [DEPTH];
  logic [31:0] shadow2 [16];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] nxt(input logic [11:0] a, input logic [1:0] b);
    int n;
    if (b == 2'b00) return a + 12'd1;
    n = 2 << b;
    return 12'((int'(a) / n) * n + ((int'(a) % n) + 1) % n);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] s);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (s[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic side();
    chk("R11 err/rty", {30'd0, err, rty}, 32'd0);
  endtask

  task automatic idle(input int n);
    stb = 0; cyc = 0; we = 0; cti = 3'b000;
    repeat (n) begin
      @(negedge clk); chk("R1 idle ack", {31'd0, ack}, 32'd0);
      @(posedge clk); #1;
    end
  endtask

  task automatic classic(input logic [11:0] a, input logic w, input logic [3:0] s,
                         input logic [2:0] c, input string wreq);
    logic [31:0] d;
    d = $urandom;
    adr = a; we = w; sel = s; dat = d; cti = c; bte = 2'($urandom);
    tag = 3'($urandom); stb = 1; cyc = 1;
    @(negedge clk);
    chk(wreq, {31'd0, ack}, 32'd0);
    if (en2) chk("R10 single wait", {31'd0, ack2}, 32'd0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R1 ack", {31'd0, ack}, 32'd1);
    side();
    if (!w) chk("R1 read data", dat_o, shadow[a]);
    else shadow[a] = merge(shadow[a], d, s);
    if (en2) begin
      chk("R10 single ack", {31'd0, ack2}, 32'd1);
      if (!w) chk("R2 full-word data", dat2, shadow2[a[3:0]]);
      else shadow2[a[3:0]] = d;
    end
    @(posedge clk); #1;
  endtask

  task automatic burst(input logic [11:0] a0, input int n, input logic [1:0] b,
                       input logic w, input bit garb, input int gap, input bit fullsel);
    logic [11:0] a;
    a = a0;
    for (int k = 0; k < n; k++) begin
      bit first;
      logic [31:0] d;
      logic [3:0] s;
      if (k == gap) begin
        stb = 0;
        @(negedge clk); chk("R9 drop same cycle", {31'd0, ack}, 32'd0);
        @(posedge clk); #1;
      end
      first = (k == 0) || (k == gap);
      d = $urandom;
      s = fullsel ? 4'hF : 4'($urandom);
      adr = (first || !garb) ? a : 12'($urandom);
      cti = (k == n - 1) ? 3'b111 : 3'b010;
      bte = b; we = w; sel = s; dat = d; tag = 3'($urandom); stb = 1; cyc = 1;
      if (first) begin
        @(negedge clk);
        chk(k == 0 ? "R4 first wait" : "R9 resume wait", {31'd0, ack}, 32'd0);
        @(posedge clk); #1;
      end
      @(negedge clk);
      chk("R4 beat ack", {31'd0, ack}, 32'd1);
      side();
      if (en2 && k == 0) begin
        chk("R10 first ack", {31'd0, ack2}, 32'd1);
        chk("R10 first data", dat2, shadow2[a[3:0]]);
      end
      if (en2 && k == 1 && gap != 1) chk("R10 no streaming", {31'd0, ack2}, 32'd0);
      if (!w) chk(b == 2'b00 ? "R5 linear data" : "R6 wrap data", dat_o, shadow[a]);
      else shadow[a] = merge(shadow[a], d, s);
      a = nxt(a, b);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R12 reset ack", {31'd0, ack}, 32'd0);
    side();
    @(posedge clk); #1;

    // Fill memory with one long linear write burst (bus address scrambled after beat 0).
    burst(12'd0, DEPTH, 2'b00, 1'b1, 1'b1, -1, 1'b1);

    // R5: linear burst over the top of the address space.
    burst(12'd4094, 4, 2'b00, 1'b0, 1'b1, -1, 1'b0);

    // R6: wrap bursts, writes then reads.
    burst(12'h102, 6, 2'b01, 1'b1, 1'b1, -1, 1'b0);
    burst(12'h102, 6, 2'b01, 1'b0, 1'b1, -1, 1'b0);
    burst(12'h2F5, 9, 2'b10, 1'b0, 1'b1, -1, 1'b0);
    burst(12'h3FE, 18, 2'b11, 1'b1, 1'b1, -1, 1'b0);
    burst(12'h3FE, 18, 2'b11, 1'b0, 1'b1, -1, 1'b0);
    idle(1);

    // R2: partial byte write then read; R3/R8 back-to-back single cycles.
    classic(12'h040, 1'b1, 4'b0101, 3'b000, "R3 wait");
    classic(12'h040, 1'b0, 4'b0000, 3'b000, "R3 back-to-back gap");
    classic(12'h041, 1'b0, 4'b0000, 3'b001, "R8 fixed-address wait");
    classic(12'h042, 1'b0, 4'b0000, 3'b001, "R8 fixed-address gap");
    classic(12'h043, 1'b1, 4'b1010, 3'b011, "R8 unused code wait");
    classic(12'h043, 1'b0, 4'b0000, 3'b110, "R8 unused code gap");
    classic(12'h044, 1'b0, 4'b0000, 3'b111, "R8 end code gap");
    idle(1);

    // R10 and the R2 lane-disable case on the second instance.
    en2 = 1;
    for (int i = 0; i < 16; i++) classic(12'(i), 1'b1, 4'($urandom), 3'b000, "R10 fill wait");
    for (int i = 0; i < 16; i++) classic(12'(i), 1'b0, 4'b0000, 3'b000, "R10 read wait");
    idle(1);
    burst(12'h005, 4, 2'b00, 1'b0, 1'b0, -1, 1'b0);
    en2 = 0;
    idle(1);

    // R7: after the end beat, the next access follows the bus address.
    burst(12'h600, 5, 2'b00, 1'b0, 1'b1, -1, 1'b0);
    classic(12'h7A3, 1'b0, 4'b0000, 3'b000, "R7 ack low after end beat");
    idle(1);

    // R9: strobe gap in linear and wrapping bursts.
    burst(12'h200, 6, 2'b00, 1'b0, 1'b1, 2, 1'b0);
    burst(12'h30D, 8, 2'b01, 1'b1, 1'b1, 3, 1'b0);
    burst(12'h30D, 8, 2'b01, 1'b0, 1'b0, 5, 1'b0);
    idle(1);

    // R12: reset in the middle of a burst, memory retained.
    adr = 12'h123; cti = 3'b010; bte = 2'b00; we = 0; stb = 1; cyc = 1;
    @(negedge clk); chk("R12 pre wait", {31'd0, ack}, 32'd0);
    @(posedge clk); #1;
    @(negedge clk); chk("R12 pre ack", {31'd0, ack}, 32'd1);
    @(posedge clk); #1;
    rst = 1; stb = 0; cyc = 0;
    @(negedge clk); chk("R12 ack cleared", {31'd0, ack}, 32'd0);
    @(posedge clk); #1;
    rst = 0;
    classic(12'h123, 1'b0, 4'b0000, 3'b000, "R12 fresh start wait");
    classic(12'h4FF, 1'b0, 4'b0000, 3'b000, "R12 fresh start gap");
    idle(1);

    // Random mix; tags are random throughout (R11).
    for (int t = 0; t < 300; t++) begin
      if ($urandom % 3 == 0) begin
        logic [2:0] c;
        c = 3'($urandom);
        if (c == 3'b010) c = 3'b000;
        classic(12'($urandom), 1'($urandom), 4'($urandom), c, "R8 random single wait");
      end else begin
        int n, g;
        n = 1 + int'($urandom % 20);
        g = (n > 1 && ($urandom % 4 == 0)) ? 1 + int'($urandom % (n - 1)) : -1;
        burst(12'($urandom), n, 2'($urandom), 1'($urandom), 1'($urandom), g, 1'b0);
      end
      if ($urandom % 2 == 0) idle(int'($urandom % 3) + 1);
    end
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule